// File: doc/BRIEF.md
# SPI Channel Transfer Engine

This block is the control for a single SPI channel. It holds a 23-bit configuration word, a transmit word, a receive word and three status flags: receive-full, transmit-empty and end-of-transfer. Register-level strobes reach it from the bus side. A transmit write loads the outgoing word. A receive read consumes the incoming word. A configuration write and an enable write complete the set. Any of these strobes can request a transfer attempt. The attempt is then judged against the enable bit, the transfer mode and the flow-control rules.

An attempt that passes runs a serial exchange through a small shifter, in SPI mode 0 and MSB first, over a word length taken from the configuration. When the exchange finishes the status flags are updated. The block drives one DMA request per direction, each gated by its own configuration bit. It also sends single-cycle event pulses to an interrupt aggregator. A module-level single-channel input can suppress the serial exchange unless the channel's force bit is set. In that case the status still completes.

The control state machine has five states. From IDLE, a pending attempt takes the *attempt* transition to CHECK. CHECK can leave four ways:
- *disabled* returns to IDLE.
- *blocked* goes to NOTIFY.
- *drive* goes to SHIFT.
- *quiet* goes to FINISH, with no serial exchange.

SHIFT takes *shift-done* to FINISH. FINISH takes *complete* to NOTIFY. NOTIFY takes *report* back to IDLE.

The shifter has its own three states. SH_IDLE takes *load* to SH_LOW. SH_LOW takes *rise* to SH_HIGH. SH_HIGH takes *fall* back to SH_LOW, or takes *last-fall* to SH_IDLE.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset the configuration reads 0x060000, the status reads 3'b010 (bit 0 receive-full, bit 1 transmit-empty, bit 2 end-of-transfer), the transmit word is 0, both DMA requests are low, the serial clock is low and busy is low.
- R2: A configuration write stores only the low 23 bits of the written value. The stored word reads back unchanged.
- R3: The word length is configuration bits 11:7 plus one. A field value below 3 is treated as a 4-bit word. The receive word is right-aligned in the low bits.
- R4: With enable clear, a transmit write loads the word and clears transmit-empty, but no transfer runs. Raising enable from 0 to 1 makes a transfer attempt.
- R5: An attempt is blocked while receive-full is set, unless the mode (configuration bits 13:12, where 0 is transmit-and-receive, 1 is receive-only, 2 is transmit-only and 3 behaves as 0) is transmit-only or the turbo bit (configuration bit 19) is set. An attempt is also blocked while transmit-empty is set, unless the mode is receive-only.
- R6: On completion the transmit word clears and end-of-transfer and transmit-empty are set. Receive-full is set unless the mode is transmit-only. The receive word is loaded with the exchanged data.
- R7: When the single-channel input is high and the force bit (configuration bit 20) is clear, the serial clock does not toggle and the receive word is unchanged. The status still completes.
- R8: The transmit DMA request is high exactly when the channel is enabled, configuration bit 14 is set, transmit-empty is set and the mode is not receive-only.
- R9: The receive DMA request is high exactly when the channel is enabled, configuration bit 15 is set, receive-full is set and the mode is not transmit-only.
- R10: A receive read returns the held word, clears receive-full and makes a transfer attempt. In receive-only mode this starts the next exchange.
- R11: After each enabled attempt, the receive event pulses for one cycle if receive-full is set, the mode is not transmit-only and turbo is clear. The transmit event pulses for one cycle if transmit-empty is set and the mode is not receive-only.
- R12: A transmit write is ignored while busy. A transmit write accepted when idle clears end-of-transfer.
- R13: The serial clock idles low. Each bit takes 2*HALF_CYC clock cycles. The first bit sent is the word's MSB. MISO is sampled on the rising serial clock edge. Busy stays high until the last bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| single_ch_mode | input | 1 | Module single-channel mode; suppresses the exchange unless forced |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 23 | Configuration write data |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write value |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_wdata | input | DATA_W | Transmit data |
| rx_rd | input | 1 | Receive data read strobe |
| cfg_rd | output | 23 | Stored configuration |
| chan_en | output | 1 | Channel enable |
| status | output | 3 | {end-of-transfer, transmit-empty, receive-full} |
| tx_word | output | DATA_W | Held transmit word |
| rx_rdata | output | DATA_W | Held receive word |
| busy | output | 1 | Control machine not idle |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| evt_rx_full | output | 1 | Receive-full event pulse |
| evt_tx_empty | output | 1 | Transmit-empty event pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong flag in the status register shows up at once on the status port. It also reaches the DMA request outputs in the same cycle. It decides the next attempt, so the error shows again as a missing or extra exchange within three cycles of the next strobe. A shifter that loses a bit, or sends the word in the wrong order, gives a wrong receive word or a wrong count of serial clock edges. This is visible as soon as end-of-transfer rises. A wrong control state would skip or repeat the event pulses in the NOTIFY cycle. It would also leave busy high beyond the 2*HALF_CYC*length window.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    localparam int CFG_W     = 23;
    localparam int WL_LSB    = 7;
    localparam int WL_MSB    = 11;
    localparam int LEN_W     = WL_MSB - WL_LSB + 1;
    localparam int MODE_LSB  = 12;
    localparam int TXDMA_BIT = 14;
    localparam int RXDMA_BIT = 15;
    localparam int TURBO_BIT = 19;
    localparam int FORCE_BIT = 20;
    localparam int MIN_LEN_M1 = 3;

    localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

    typedef enum logic [1:0] {
        XM_FULL    = 2'd0,
        XM_RX_ONLY = 2'd1,
        XM_TX_ONLY = 2'd2,
        XM_RSVD    = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SHIFT,
        ST_FINISH,
        ST_NOTIFY
    } ctl_state_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_state_e;

    typedef struct packed {
        logic eot;
        logic tx_empty;
        logic rx_full;
    } chan_stat_t;

endpackage

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
    import spi_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              busy,
    input  logic              pend_take,
    input  logic              xfer_done,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_in,
    output logic [CFG_W-1:0]  cfg,
    output logic              enable,
    output chan_stat_t        stat,
    output logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rx_word,
    output logic              pend,
    output logic              tx_dma,
    output logic              rx_dma
);

    logic [CFG_W-1:0]  cfg_q;
    logic              en_q;
    chan_stat_t        st_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              pend_q;
    xfer_mode_e        mode;
    logic              tx_accept;
    logic              en_rise;

    assign mode      = xfer_mode_e'(cfg_q[MODE_LSB+1:MODE_LSB]);
    assign tx_accept = tx_wr && !busy;
    assign en_rise   = en_wr && en_wdata && !en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            en_q   <= 1'b0;
            st_q   <= '{eot: 1'b0, tx_empty: 1'b1, rx_full: 1'b0};
            tx_q   <= '0;
            rx_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_wdata;
            if (en_wr)  en_q  <= en_wdata;
            if (tx_accept) begin
                tx_q          <= tx_wdata;
                st_q.tx_empty <= 1'b0;
                st_q.eot      <= 1'b0;
            end
            if (rx_rd) st_q.rx_full <= 1'b0;
            if (xfer_done) begin
                tx_q          <= '0;
                st_q.eot      <= 1'b1;
                st_q.tx_empty <= 1'b1;
                if (mode != XM_TX_ONLY) st_q.rx_full <= 1'b1;
            end
            if (rx_load) rx_q <= rx_in;
            if (tx_accept || rx_rd || en_rise) pend_q <= 1'b1;
            else if (pend_take)                pend_q <= 1'b0;
        end
    end

    assign cfg     = cfg_q;
    assign enable  = en_q;
    assign stat    = st_q;
    assign tx_word = tx_q;
    assign rx_word = rx_q;
    assign pend    = pend_q;
    assign tx_dma  = en_q && cfg_q[TXDMA_BIT] && st_q.tx_empty && (mode != XM_RX_ONLY);
    assign rx_dma  = en_q && cfg_q[RXDMA_BIT] && st_q.rx_full  && (mode != XM_TX_ONLY);

    // R6
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (st_q.tx_empty && st_q.eot && tx_q == '0));

    // R12
    busy_tx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy && !xfer_done) |=> $stable(tx_q));

endmodule

// File: rtl/spi_chan_ctl.sv
module spi_chan_ctl
    import spi_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend,
    input  logic       enable,
    input  chan_stat_t stat,
    input  xfer_mode_e mode,
    input  logic       turbo,
    input  logic       force_drive,
    input  logic       single_ch,
    input  logic       sh_done,
    output logic       pend_take,
    output logic       sh_start,
    output logic       xfer_done,
    output logic       rx_load,
    output logic       evt_rx_full,
    output logic       evt_tx_empty,
    output logic       busy
);

    ctl_state_e st_q, st_d;
    logic       drove_q, drove_d;
    logic       blocked;
    logic       drive_ok;

    assign blocked  = (stat.rx_full && (mode != XM_TX_ONLY) && !turbo) ||
                      (stat.tx_empty && (mode != XM_RX_ONLY));
    assign drive_ok = !single_ch || force_drive;

    always_comb begin
        st_d    = st_q;
        drove_d = drove_q;
        unique case (st_q)
            ST_IDLE:   if (pend) st_d = ST_CHECK;
            ST_CHECK: begin
                if (!enable)       st_d = ST_IDLE;
                else if (blocked)  st_d = ST_NOTIFY;
                else if (drive_ok) begin st_d = ST_SHIFT;  drove_d = 1'b1; end
                else               begin st_d = ST_FINISH; drove_d = 1'b0; end
            end
            ST_SHIFT:  if (sh_done) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_NOTIFY;
            ST_NOTIFY: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend_take    = 1'b0;
        sh_start     = 1'b0;
        xfer_done    = 1'b0;
        rx_load      = 1'b0;
        evt_rx_full  = 1'b0;
        evt_tx_empty = 1'b0;
        unique case (st_q)
            ST_IDLE:   pend_take = pend;
            ST_CHECK:  sh_start  = enable && !blocked && drive_ok;
            ST_SHIFT:  ;
            ST_FINISH: begin
                xfer_done = 1'b1;
                rx_load   = drove_q;
            end
            ST_NOTIFY: begin
                evt_rx_full  = stat.rx_full && (mode != XM_TX_ONLY) && !turbo;
                evt_tx_empty = stat.tx_empty && (mode != XM_RX_ONLY);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            drove_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            drove_q <= drove_d;
        end
    end

    assign busy = (st_q != ST_IDLE);

    // R11
    evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rx_full || evt_tx_empty) |=> !(evt_rx_full || evt_tx_empty));

    // R13
    done_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |-> (st_q == ST_SHIFT));

endmodule

// File: rtl/spi_chan_shifter.sv
module spi_chan_shifter
    import spi_chan_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);

    localparam int DIV_W = $clog2(HALF_CYC + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);
    localparam logic [LEN_W-1:0] TOP_IDX  = LEN_W'(DATA_W - 1);

    sh_state_e         sh_q;
    logic [DIV_W-1:0]  div_q;
    logic [LEN_W-1:0]  bit_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] txsh_q;
    logic [DATA_W-1:0] rxsh_q;
    logic              sclk_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= SH_IDLE;
            div_q  <= '0;
            bit_q  <= '0;
            len_q  <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (sh_q)
                SH_IDLE: begin
                    if (start) begin
                        txsh_q <= tx_word << (TOP_IDX - len_m1);
                        rxsh_q <= '0;
                        len_q  <= len_m1;
                        bit_q  <= '0;
                        div_q  <= '0;
                        sh_q   <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (div_q == DIV_LAST) begin
                        div_q  <= '0;
                        sclk_q <= 1'b1;
                        rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
                        sh_q   <= SH_HIGH;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (div_q == DIV_LAST) begin
                        div_q  <= '0;
                        sclk_q <= 1'b0;
                        if (bit_q == len_q) begin
                            sh_q   <= SH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            bit_q  <= bit_q + 1'b1;
                            txsh_q <= txsh_q << 1;
                            sh_q   <= SH_LOW;
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: sh_q <= SH_IDLE;
            endcase
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = txsh_q[DATA_W-1];
    assign busy    = (sh_q != SH_IDLE);
    assign done    = done_q;
    assign rx_word = rxsh_q;

    // R13
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk_q);

    // R13
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(sh_q) == SH_HIGH && !busy));

endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
    import spi_chan_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_ch_mode,
    input  logic              cfg_wr,
    input  logic [22:0]       cfg_wdata,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [22:0]       cfg_rd,
    output logic              chan_en,
    output logic [2:0]        status,
    output logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              busy,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              evt_rx_full,
    output logic              evt_tx_empty,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic [CFG_W-1:0]  cfg;
    logic              enable;
    chan_stat_t        stat;
    logic              pend, pend_take;
    logic              sh_start, sh_done, sh_busy;
    logic              xfer_done, rx_load;
    logic [DATA_W-1:0] sh_rx;
    logic [LEN_W-1:0]  wl_field, len_m1;
    xfer_mode_e        mode;

    assign mode     = xfer_mode_e'(cfg[MODE_LSB+1:MODE_LSB]);
    assign wl_field = cfg[WL_MSB:WL_LSB];
    assign len_m1   = (wl_field < LEN_W'(MIN_LEN_M1)) ? LEN_W'(MIN_LEN_M1) : wl_field;

    spi_chan_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .tx_wr     (tx_wr),
        .tx_wdata  (tx_wdata),
        .rx_rd     (rx_rd),
        .busy      (busy),
        .pend_take (pend_take),
        .xfer_done (xfer_done),
        .rx_load   (rx_load),
        .rx_in     (sh_rx),
        .cfg       (cfg),
        .enable    (enable),
        .stat      (stat),
        .tx_word   (tx_word),
        .rx_word   (rx_rdata),
        .pend      (pend),
        .tx_dma    (tx_dma_req),
        .rx_dma    (rx_dma_req)
    );

    spi_chan_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend         (pend),
        .enable       (enable),
        .stat         (stat),
        .mode         (mode),
        .turbo        (cfg[TURBO_BIT]),
        .force_drive  (cfg[FORCE_BIT]),
        .single_ch    (single_ch_mode),
        .sh_done      (sh_done),
        .pend_take    (pend_take),
        .sh_start     (sh_start),
        .xfer_done    (xfer_done),
        .rx_load      (rx_load),
        .evt_rx_full  (evt_rx_full),
        .evt_tx_empty (evt_tx_empty),
        .busy         (busy)
    );

    spi_chan_shifter #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_word (tx_word),
        .len_m1  (len_m1),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    assign cfg_rd  = cfg;
    assign chan_en = enable;
    assign status  = stat;

    // R7
    quiet_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_ch_mode && !cfg[FORCE_BIT] && !sh_busy) |=> !spi_sclk);

endmodule

// File: tb/spi_chan_engine_bench.sv
module spi_chan_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        single_ch_mode = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [22:0] cfg_wdata = '0;
    logic        en_wr = 1'b0, en_wdata = 1'b0;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [22:0] cfg_rd;
    logic        chan_en;
    logic [2:0]  status;
    logic [31:0] tx_word, rx_rdata;
    logic        busy, tx_dma_req, rx_dma_req, evt_rx_full, evt_tx_empty;
    logic        spi_sclk, spi_mosi, spi_miso;
    int          miso_sel = 0;

    always #2.5 clk = ~clk;

    assign spi_miso = (miso_sel == 0) ? spi_mosi : 1'b1;

    spi_chan_engine u_spi_chan_engine (.*);

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] exp_q[$];
    int rises = 0, n_evt_rx = 0, n_evt_tx = 0;
    int last_rise = 0, rise_gap = 0;
    logic [31:0] cap = '0;
    logic prev_sclk = 1'b0, prev_eot = 1'b0;
    logic [31:0] e;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard, serial clock edges, events
    always @(negedge clk) begin
        if (rst_n) begin
            if (status[2] && !prev_eot && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(rx_rdata == e, "R6 scoreboard rx word", rx_rdata, e);
            end
            if (spi_sclk && !prev_sclk) begin
                rises++;
                cap = {cap[30:0], spi_mosi};
                rise_gap = cyc - last_rise;
                last_rise = cyc;
            end
            if (evt_rx_full)  n_evt_rx++;
            if (evt_tx_empty) n_evt_tx++;
            prev_sclk = spi_sclk;
            prev_eot  = status[2];
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [22:0] mk_cfg(input int mode, input int wl, input logic [22:0] flags);
        return flags | (23'(mode) << 12) | (23'(wl) << 7);
    endfunction

    task automatic pulse_cfg(input logic [22:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic write_tx(input logic [31:0] v);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] v, input logic [31:0] exp);
        exp_q.push_back(exp);
        write_tx(v);
    endtask

    task automatic read_rx(output logic [31:0] v);
        @(negedge clk); rx_rd = 1'b1; v = rx_rdata;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clr_counts();
        rises = 0; n_evt_rx = 0; n_evt_tx = 0; cap = '0;
    endtask

    localparam logic [22:0] F_TXDMA = 23'h1 << 14;
    localparam logic [22:0] F_RXDMA = 23'h1 << 15;
    localparam logic [22:0] F_TURBO = 23'h1 << 19;
    localparam logic [22:0] F_FORCE = 23'h1 << 20;

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cfg_rd == 23'h060000, "R1 cfg", 32'(cfg_rd), 32'h060000);
        chk(status == 3'b010, "R1 status", 32'(status), 32'h2);
        chk(tx_word == 0 && !tx_dma_req && !rx_dma_req, "R1 tx/dma", tx_word, 0);
        chk(!spi_sclk && !busy, "R1 sclk/busy", {30'b0, spi_sclk, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 stores low 23 bits
        pulse_cfg(23'h7FFFFF);
        chk(cfg_rd == 23'h7FFFFF, "R2 cfg readback", 32'(cfg_rd), 32'h7FFFFF);
        pulse_cfg(mk_cfg(0, 7, 0));
        chk(cfg_rd == 23'h000380, "R2 cfg readback", 32'(cfg_rd), 32'h380);

        // R4 disabled: write loads word, no transfer
        clr_counts();
        write_tx(32'hA5);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(status == 3'b000, "R4 disabled status", 32'(status), 0);
        chk(tx_word == 32'hA5 && rises == 0, "R4 disabled no clock", tx_word, 32'hA5);

        // R4 enable rise starts exchange; R13 MSB first and bit time
        exp_q.push_back(32'hA5);
        set_en(1'b1);
        wait_idle();
        chk(status == 3'b111, "R6 status after exchange", 32'(status), 32'h7);
        chk(tx_word == 0, "R6 tx cleared", tx_word, 0);
        chk(rises == 8, "R13 bit count", rises, 8);
        chk(cap[7:0] == 8'hA5, "R13 MSB first", 32'(cap[7:0]), 32'hA5);
        chk(rise_gap == 4, "R13 bit period", rise_gap, 4);
        chk(n_evt_rx == 1 && n_evt_tx == 1, "R11 events after exchange", n_evt_rx*16+n_evt_tx, 32'h11);

        // R5 blocked by receive-full
        clr_counts();
        write_tx(32'h3C);
        wait_idle();
        chk(status == 3'b001 && rises == 0, "R5 blocked by rx full", 32'(status), 32'h1);
        chk(tx_word == 32'h3C && rx_rdata == 32'hA5, "R5 blocked keeps words", tx_word, 32'h3C);
        chk(n_evt_rx == 1 && n_evt_tx == 0, "R11 events when blocked", n_evt_rx*16+n_evt_tx, 32'h10);

        // R10 read clears rx full and restarts
        exp_q.push_back(32'h3C);
        read_rx(rv);
        chk(rv == 32'hA5, "R10 read returns held word", rv, 32'hA5);
        wait_idle();
        chk(status == 3'b111, "R10 read-triggered exchange", 32'(status), 32'h7);

        // R6 transmit-only leaves receive-full clear
        pulse_cfg(mk_cfg(2, 15, 0));
        read_rx(rv);
        wait_idle();
        send_word(32'hBEEF, 32'hBEEF);
        wait_idle();
        chk(status == 3'b110, "R6 tx-only rx full clear", 32'(status), 32'h6);

        // R5 turbo: runs despite rx full; R11 no rx event
        pulse_cfg(mk_cfg(0, 7, 0));
        send_word(32'h1234, 32'h34);
        wait_idle();
        pulse_cfg(mk_cfg(0, 7, F_TURBO));
        clr_counts();
        send_word(32'h5A, 32'h5A);
        wait_idle();
        chk(status == 3'b111 && rises == 8, "R5 turbo bypasses rx full", 32'(status), 32'h7);
        chk(n_evt_rx == 0 && n_evt_tx == 1, "R11 turbo suppresses rx event", n_evt_rx*16+n_evt_tx, 32'h01);

        // R7 single-channel without force: no clock, rx unchanged
        single_ch_mode = 1'b1;
        clr_counts();
        send_word(32'h77, 32'h5A);
        wait_idle();
        chk(rises == 0 && status == 3'b111 && tx_word == 0, "R7 quiet completion", rises, 0);
        pulse_cfg(mk_cfg(0, 7, F_TURBO | F_FORCE));
        clr_counts();
        send_word(32'h66, 32'h66);
        wait_idle();
        chk(rises == 8, "R7 force drives", rises, 8);

        // R12 transmit write while busy is ignored
        clr_counts();
        send_word(32'h99, 32'h99);
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R12 busy during exchange", 32'(busy), 1);
        write_tx(32'h11);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(rises == 8 && tx_word == 0, "R12 write during busy ignored", rises, 8);

        // R3 length clamp and full length
        pulse_cfg(mk_cfg(0, 1, F_TURBO | F_FORCE));
        clr_counts();
        send_word(32'hF3, 32'h3);
        wait_idle();
        chk(rises == 4, "R3 short field clamps to 4", rises, 4);
        pulse_cfg(mk_cfg(0, 31, F_TURBO | F_FORCE));
        miso_sel = 1;
        clr_counts();
        send_word(32'h80000001, 32'hFFFFFFFF);
        wait_idle();
        chk(rises == 32, "R3 32-bit word", rises, 32);

        // R10 receive-only: read starts next exchange
        pulse_cfg(mk_cfg(1, 7, F_FORCE));
        read_rx(rv);
        wait_idle();
        chk(rx_rdata == 32'hFF && status[0], "R10 rx-only read restarts", rx_rdata, 32'hFF);
        miso_sel = 0;

        // R8 transmit DMA gating
        pulse_cfg(mk_cfg(2, 15, F_TXDMA));
        chk(tx_dma_req == 1'b1, "R8 tx dma on", 32'(tx_dma_req), 1);
        pulse_cfg(mk_cfg(1, 15, F_TXDMA));
        chk(tx_dma_req == 1'b0, "R8 tx dma off in rx-only", 32'(tx_dma_req), 0);

        // R9 receive DMA gating
        pulse_cfg(mk_cfg(0, 7, F_RXDMA));
        chk(rx_dma_req == 1'b1, "R9 rx dma on", 32'(rx_dma_req), 1);
        pulse_cfg(mk_cfg(2, 7, F_RXDMA));
        chk(rx_dma_req == 1'b0, "R9 rx dma off in tx-only", 32'(rx_dma_req), 0);
        pulse_cfg(mk_cfg(0, 7, F_RXDMA));
        set_en(1'b0);
        chk(rx_dma_req == 1'b0, "R9 rx dma off when disabled", 32'(rx_dma_req), 0);
        set_en(1'b1);
        wait_idle();
        chk(rx_dma_req == 1'b1, "R9 rx dma back on", 32'(rx_dma_req), 1);
        read_rx(rv);
        wait_idle();
        chk(rx_dma_req == 1'b0 && status[0] == 1'b0, "R9 rx dma clears on read", 32'(rx_dma_req), 0);

        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule